// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block is the status and write-enable part of a serial flash device's SPI target port. It watches the chip-select, serial clock and serial data inputs and decodes four single-byte commands: set write-enable, clear write-enable, read status and write status. It holds the write-enable latch, three block-protect bits and a status-lock bit. During a status read it shifts the status byte out on the data output, and it keeps repeating that byte for as long as chip select stays low. Each repeat carries the current value of the status.

A countdown timer models the busy time of status writes and of program or erase operations. The flash core asks for a program or erase operation with a one-cycle start pulse on a side port. The block grants that request only when the write-enable latch is set and the device is not busy. When a busy period ends, the write-enable latch clears by itself.

The SPI inputs are sampled by the block's own clock. They are taken to be synchronous and at least four clock cycles per serial clock phase. Both SPI mode 0 (clock idles low) and mode 3 (clock idles high) are accepted.

Top module: `sfsr_status_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, `spi_so_oe` is 0 and `protect_o` is 0.
- R2: Read-status (opcode 0x05) returns the status byte MSB first. Bit 7 is the lock bit, bits 6 and 5 read 0, bits 4..2 are the protect bits (also on `protect_o`), bit 1 is the write-enable latch and bit 0 is the busy flag. SO changes after a falling SCK edge so that the host can sample it on the next rising edge.
- R3: A frame of exactly 8 bits holding opcode 0x06 sets the write-enable latch.
- R4: A frame of exactly 8 bits holding opcode 0x04 clears the write-enable latch.
- R5: A frame of exactly 16 bits (opcode 0x01 then one data byte) with the latch set loads the lock bit from data bit 7 and the protect bits from data bits 4..2, then holds busy for WRSR_CYCLES clock cycles. With the latch clear the frame is ignored.
- R6: At the end of any busy period, busy returns to 0 and the write-enable latch clears.
- R7: Read-status is served while busy. Every repeated byte in one frame shows the status as it is at that moment.
- R8: While busy, every command other than read-status is ignored.
- R9: When the lock bit is 1 and `wp_n` is 0, a status write is refused and the latch is left unchanged. When `wp_n` is 1, the write is accepted.
- R10: A frame whose bit count is not the exact length of its command is discarded. This covers counts that are not a multiple of 8 and extra bytes.
- R11: A pulse on `op_start` starts a busy period of OP_CYCLES cycles only if the latch is 1 and the device is not busy. Otherwise the pulse is ignored.
- R12: `spi_so_oe` is 1 only while status bits are being shifted, and it drops once chip select is high. This holds in mode 0 and in mode 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock, synchronous to clk |
| spi_csn | input | 1 | Active-low chip select |
| spi_si | input | 1 | Serial data in |
| spi_so | output | 1 | Serial data out |
| spi_so_oe | output | 1 | Drive enable for spi_so (0 = high impedance) |
| wp_n | input | 1 | Active-low hardware write protect |
| op_start | input | 1 | Program/erase start request from the flash core |
| protect_o | output | 3 | Current block-protect bits |

## Verification
The status byte is read back after single commands, after truncated frames (7 and 11 bits) and after over-long frames (24 bits). This separates acceptance by length from acceptance by opcode. Status writes are tried with the latch clear, with the lock bit set and the pin both low and high, and with the device busy, so that each gating condition is observed to refuse or pass on its own. Two-byte reads during a busy period and a read after it ends show both the repeat behaviour and the automatic latch clear. Mode 3 framing is exercised next to mode 0 to show that the idle clock level does not change decoding.

// File: rtl/sfsr_pkg.sv
// Shared constants for the serial flash status controller.
package sfsr_pkg;
    localparam logic [7:0] OPC_SET_WE  = 8'h06;
    localparam logic [7:0] OPC_CLR_WE  = 8'h04;
    localparam logic [7:0] OPC_RD_STAT = 8'h05;
    localparam logic [7:0] OPC_WR_STAT = 8'h01;
    localparam int         LEN_CMD     = 8;
    localparam int         LEN_WR_STAT = 16;

    // Builds the status byte from its fields.
    function automatic logic [7:0] pack_status(input logic lock, input logic [2:0] prot,
                                               input logic we, input logic busy);
        return {lock, 2'b00, prot, we, busy};
    endfunction
endpackage

// File: rtl/sfsr_spi_rx.sv
// SPI receive front end: finds SCK and chip-select edges in the clk domain,
// counts frame bits, captures the first byte as opcode and keeps the last
// byte shifted in. Assumes SPI inputs are already synchronous to clk and
// that each SCK phase lasts at least two clk cycles.
module sfsr_spi_rx #(
    parameter int FRAME_CAP = 31
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          sck,
    input  logic                          csn,
    input  logic                          si,
    output logic                          sck_fall,
    output logic                          frame_end,
    output logic                          opc_valid,
    output logic [7:0]                    opc_next,
    output logic [7:0]                    opcode,
    output logic [7:0]                    last_byte,
    output logic [$clog2(FRAME_CAP+1)-1:0] bit_cnt
);
    localparam int BCW = $clog2(FRAME_CAP + 1);

    logic sck_q, csn_q, sck_rise;

    // Delays SCK and chip select by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_q <= 1'b0;
            csn_q <= 1'b1;
        end else begin
            sck_q <= sck;
            csn_q <= csn;
        end
    end

    assign sck_rise  = sck & ~sck_q & ~csn;
    assign sck_fall  = ~sck & sck_q & ~csn;
    assign frame_end = csn & ~csn_q;
    assign opc_next  = {last_byte[6:0], si};
    assign opc_valid = sck_rise && (bit_cnt == BCW'(7));

    // Counts bits of the current frame, saturating at FRAME_CAP.
    always_ff @(posedge clk) begin
        if (!rst_n)                                 bit_cnt <= '0;
        else if (csn)                               bit_cnt <= '0;
        else if (sck_rise && bit_cnt != BCW'(FRAME_CAP)) bit_cnt <= bit_cnt + BCW'(1);
    end

    // Shifts serial data in MSB first and latches the opcode byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_byte <= '0;
            opcode    <= '0;
        end else if (sck_rise) begin
            last_byte <= opc_next;
            if (opc_valid) opcode <= opc_next;
        end
    end

    p_count_steps_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!csn && !$past(csn) && bit_cnt != $past(bit_cnt)) |-> (bit_cnt == $past(bit_cnt) + BCW'(1)));
endmodule

// File: rtl/sfsr_so_tx.sv
// Status transmitter: once a read is active, each falling SCK edge puts the
// next status bit on SO. Every eighth bit boundary reloads the live status.
// SO is enabled from the first falling edge of the read until chip select
// goes high.
module sfsr_so_tx (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       csn,
    input  logic       sck_fall,
    input  logic       reading,
    input  logic [7:0] status,
    output logic       so,
    output logic       so_oe
);
    logic [7:0] sh;
    logic [2:0] pos;

    // Drives SO bit by bit and controls its enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            so    <= 1'b0;
            so_oe <= 1'b0;
            sh    <= '0;
            pos   <= '0;
        end else if (csn) begin
            so_oe <= 1'b0;
            pos   <= '0;
        end else if (reading && sck_fall) begin
            so_oe <= 1'b1;
            pos   <= pos + 3'd1;
            if (pos == 3'd0) begin
                so <= status[7];
                sh <= {status[6:0], 1'b0};
            end else begin
                so <= sh[7];
                sh <= {sh[6:0], 1'b0};
            end
        end
    end

    p_so_released_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (csn && $past(csn)) |-> !so_oe);
endmodule

// File: rtl/sfsr_busy_timer.sv
// Busy countdown: a start loads the cycle count, busy stays high while the
// count is non-zero, and done pulses in the last busy cycle. A load of zero
// is not expected.
module sfsr_busy_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [CW-1:0] load,
    output logic          busy,
    output logic          done
);
    logic [CW-1:0] cnt;

    // Loads on start, otherwise counts down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= load;
        else if (cnt != '0)  cnt <= cnt - CW'(1);
    end

    assign busy = (cnt != '0);
    assign done = (cnt == CW'(1)) && !start;

    p_count_down_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && !$past(start)) |-> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/sfsr_status_ctrl.sv
// Status register controller of a serial flash SPI target. It decodes the
// set/clear write-enable, read-status and write-status commands at the end
// of each frame, holds the lock, protect and write-enable bits, and grants
// program/erase start pulses from the core. Commands are checked against the
// exact frame length. Everything except read-status is refused while busy.
module sfsr_status_ctrl #(
    parameter int WRSR_CYCLES = 4000,
    parameter int OP_CYCLES   = 20000,
    parameter int FRAME_CAP   = 31
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_csn,
    input  logic       spi_si,
    output logic       spi_so,
    output logic       spi_so_oe,
    input  logic       wp_n,
    input  logic       op_start,
    output logic [2:0] protect_o
);
    import sfsr_pkg::*;

    localparam int MAXC = (WRSR_CYCLES > OP_CYCLES) ? WRSR_CYCLES : OP_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam int BCW  = $clog2(FRAME_CAP + 1);

    logic           sck_fall, frame_end, opc_valid;
    logic [7:0]     opc_next, opcode, last_byte, status;
    logic [BCW-1:0] bit_cnt;
    logic           busy, done, start;
    logic           we, lock, reading;
    logic [2:0]     prot;
    logic           len_cmd, len_wr, do_set, do_clr, do_wr, do_op;
    logic [CW-1:0]  load;

    sfsr_spi_rx #(.FRAME_CAP(FRAME_CAP)) u_rx (
        .clk(clk), .rst_n(rst_n), .sck(spi_sck), .csn(spi_csn), .si(spi_si),
        .sck_fall(sck_fall), .frame_end(frame_end), .opc_valid(opc_valid),
        .opc_next(opc_next), .opcode(opcode), .last_byte(last_byte), .bit_cnt(bit_cnt)
    );

    sfsr_busy_timer #(.CW(CW)) u_tmr (
        .clk(clk), .rst_n(rst_n), .start(start), .load(load), .busy(busy), .done(done)
    );

    sfsr_so_tx u_tx (
        .clk(clk), .rst_n(rst_n), .csn(spi_csn), .sck_fall(sck_fall),
        .reading(reading), .status(status), .so(spi_so), .so_oe(spi_so_oe)
    );

    // Decodes a finished frame and the side-port request.
    always_comb begin
        len_cmd = (bit_cnt == BCW'(LEN_CMD));
        len_wr  = (bit_cnt == BCW'(LEN_WR_STAT));
        do_set  = frame_end && len_cmd && !busy && (opcode == OPC_SET_WE);
        do_clr  = frame_end && len_cmd && !busy && (opcode == OPC_CLR_WE);
        do_wr   = frame_end && len_wr && !busy && we && (opcode == OPC_WR_STAT)
                  && !(lock && !wp_n);
        do_op   = op_start && we && !busy && !do_wr;
        start   = do_wr || do_op;
        load    = do_wr ? CW'(WRSR_CYCLES) : CW'(OP_CYCLES);
    end

    // Holds the write-enable latch.
    always_ff @(posedge clk) begin
        if (!rst_n)               we <= 1'b0;
        else if (done || do_clr)  we <= 1'b0;
        else if (do_set)          we <= 1'b1;
    end

    // Holds the lock and protect bits written by a status write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock <= 1'b0;
            prot <= 3'b000;
        end else if (do_wr) begin
            lock <= last_byte[7];
            prot <= last_byte[4:2];
        end
    end

    // Marks a read-status frame once its opcode byte is complete.
    always_ff @(posedge clk) begin
        if (!rst_n)                                    reading <= 1'b0;
        else if (spi_csn)                              reading <= 1'b0;
        else if (opc_valid && opc_next == OPC_RD_STAT) reading <= 1'b1;
    end

    assign status    = pack_status(lock, prot, we, busy);
    assign protect_o = prot;

    p_we_clear_at_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !we);
    p_we_set_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(we) |-> !$past(busy));
    p_lock_guard_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (prot != $past(prot) || lock != $past(lock)) |-> !($past(lock) && !$past(wp_n)));
    p_write_needs_we_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(we));
endmodule

// File: tb/sim_sfsr_status_ctrl.sv
// Scoreboard bench: the caller queues expected status bytes, the SPI driver
// captures bytes from SO, and a monitor pairs and compares them.
module sim_sfsr_status_ctrl;
    timeunit 1ns;
    timeprecision 1ps;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_sck = 1'b0, spi_csn = 1'b1, spi_si = 1'b0;
    logic       wp_n = 1'b1, op_start = 1'b0;
    logic       spi_so, spi_so_oe;
    logic [2:0] protect_o;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] exp_q[$], got_q[$];
    string      tag_q[$];

    always #4 clk = ~clk;

    sfsr_status_ctrl #(.WRSR_CYCLES(400), .OP_CYCLES(300)) u0 (
        .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_csn(spi_csn), .spi_si(spi_si),
        .spi_so(spi_so), .spi_so_oe(spi_so_oe), .wp_n(wp_n), .op_start(op_start),
        .protect_o(protect_o)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_byte(input logic [7:0] e, input string tag);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    // Drives one frame: nb command bits, then rd bytes captured from SO.
    task automatic frame(input logic [31:0] d, input int nb, input int rd, input bit m3);
        logic [7:0] cap = '0;
        spi_sck = m3;
        tick(2);
        spi_csn = 1'b0;
        tick(4);
        for (int i = 0; i < nb + rd * 8; i++) begin
            spi_sck = 1'b0;
            spi_si  = (i < nb) ? d[nb-1-i] : 1'b0;
            tick(4);
            if (i >= nb) begin
                cap = {cap[6:0], spi_so};
                if (i == nb) check(spi_so_oe === 1'b1, "R12 oe during read", spi_so_oe, 1);
            end
            spi_sck = 1'b1;
            tick(4);
            if (i >= nb && ((i - nb) % 8) == 7) got_q.push_back(cap);
        end
        if (!m3) begin
            spi_sck = 1'b0;
            tick(2);
        end
        spi_csn = 1'b1;
        tick(3);
        check(spi_so_oe === 1'b0, "R12 oe after frame", spi_so_oe, 0);
    endtask

    task automatic rd_status(input int n, input bit m3);
        frame(32'h05, 8, n, m3);
    endtask

    task automatic pulse_op();
        op_start = 1'b1;
        tick(1);
        op_start = 1'b0;
        tick(1);
    endtask

    // Monitor: pairs captured bytes with expected ones.
    initial forever begin
        @(negedge clk);
        while (got_q.size() > 0 && exp_q.size() > 0) begin
            logic [7:0] g, e;
            string t;
            g = got_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(g === e, t, g, e);
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(2);
        check(spi_so_oe === 1'b0, "R1 oe at reset", spi_so_oe, 0);
        check(protect_o === 3'b000, "R1 protect at reset", protect_o, 0);
        expect_byte(8'h00, "R1 status at reset"); rd_status(1, 0);

        frame(32'h06, 8, 0, 0);                        // R3
        expect_byte(8'h02, "R3 set latch"); rd_status(1, 0);
        frame(32'h04, 8, 0, 0);                        // R4
        expect_byte(8'h00, "R4 clear latch"); rd_status(1, 0);

        frame(32'h01FC, 16, 0, 0);                     // R5 without latch
        expect_byte(8'h00, "R5 write without latch"); rd_status(1, 0);

        frame(32'h06, 8, 0, 0);
        frame(32'h01FC, 16, 0, 0);                     // R5 accepted, R2 layout
        frame(32'h04, 8, 0, 0);                        // R8 ignored while busy
        expect_byte(8'h9F, "R7 busy read byte 1");
        expect_byte(8'h9F, "R8 clear ignored while busy");
        rd_status(2, 0);
        check(protect_o === 3'b111, "R2 protect_o", protect_o, 7);
        tick(500);
        expect_byte(8'h9C, "R6 latch cleared at end"); rd_status(1, 0);

        wp_n = 1'b0;                                   // R9 locked
        frame(32'h06, 8, 0, 0);
        frame(32'h0100, 16, 0, 0);
        expect_byte(8'h9E, "R9 locked write refused"); rd_status(1, 0);
        wp_n = 1'b1;
        frame(32'h0100, 16, 0, 0);
        expect_byte(8'h03, "R9 unlocked write busy"); rd_status(1, 0);
        tick(500);
        expect_byte(8'h00, "R5 write done"); rd_status(1, 0);
        check(protect_o === 3'b000, "R5 protect cleared", protect_o, 0);

        frame(32'h03, 7, 0, 0);                        // R10 short (0x06 sent as 7 bits)
        expect_byte(8'h00, "R10 7-bit frame"); rd_status(1, 0);
        frame(32'h035, 11, 0, 0);                      // R10 0x06 plus 3 bits
        expect_byte(8'h00, "R10 11-bit frame"); rd_status(1, 0);
        frame(32'h06, 8, 0, 0);
        frame(32'h01FC00, 24, 0, 0);                   // R10 extra byte
        expect_byte(8'h02, "R10 24-bit write ignored"); rd_status(1, 0);
        frame(32'h04, 8, 0, 0);

        pulse_op();                                    // R11 without latch
        expect_byte(8'h00, "R11 op refused"); rd_status(1, 0);
        frame(32'h06, 8, 0, 0);
        pulse_op();
        expect_byte(8'h03, "R11 op busy"); rd_status(1, 0);
        tick(400);
        expect_byte(8'h00, "R6 op end clears latch"); rd_status(1, 0);

        frame(32'h06, 8, 0, 1);                        // R12 mode 3
        expect_byte(8'h02, "R12 mode 3 read"); rd_status(1, 1);
        frame(32'h04, 8, 0, 1);
        expect_byte(8'h00, "R4 mode 3 clear"); rd_status(1, 0);

        tick(20);
        check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule